// File: doc/BRIEF.md
# Frequency and Amplitude Modulation Control Law

This block turns the digitized output of a flyback converter's voltage error amplifier into two commands for the next switching cycle. The first is a minimum switching period, counted in timer ticks. The second is a code for the peak primary-current threshold. The 8-bit control word spans the whole control range. Fixed breakpoints split that range into four regions, and within each region one output is linearly interpolated while the other is held:

- **Upper region:** the current is at maximum and the period shortens toward the fastest rate.
- **Amplitude band:** the period is pinned at a mid frequency while the current threshold slides between maximum and a quarter of maximum.
- **Two lower regions:** the current stays at a quarter of maximum while the period lengthens, first to a knee and then to the slowest allowed rate.

While the current is at maximum, the block also limits the output current. It compares the measured demagnetization time against the measured switching period. Once the ratio exceeds 17/40 (0.425), the commanded period is stretched until that ratio is met again.

A one-cycle strobe at the end of each switching cycle samples the inputs. Results pass through two register stages, so both outputs change together on the second clock edge after the strobe.

Top module: `fm_am_law`

## Requirements
- R1: During and after reset, until the first strobe has been processed, `period_cmd` is PER_MAX (15385) and `ipk_code` is THR_MIN (60).
- R2: For a control word c with 181 <= c <= 255, `ipk_code` is 240 and the profile period is 357 - floor(232*(c-181)/74). This gives 357 at c=181 and 125 at c=255.
- R3: For 112 <= c <= 180, the profile period is 357 and `ipk_code` is 60 + floor(180*(c-112)/69).
- R4: For 38 <= c <= 111, `ipk_code` is 60 and the period is 3030 - floor(2673*(c-38)/74).
- R5: For 0 <= c <= 37, `ipk_code` is 60 and the period is 15385 - floor(12355*c/38).
- R6: When c >= 181 and demag*40 > meas*17, the commanded period is the larger of two values. One is the profile period. The other is ceil(demag*40/17), saturated at 15385.
- R7: When c < 181, demagnetization and period measurements have no effect on either output.
- R8: Outputs change only on the second rising clock edge after a cycle-end strobe. Input changes without a strobe leave both outputs unchanged.
- R9: `period_cmd` always lies in [125, 15385] and `ipk_code` in [60, 240]. The maximum threshold is four times the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_end | input | 1 | One-cycle strobe at the end of a switching cycle |
| ctrl_word | input | 8 | Digitized error-amplifier control word, 0 to full scale |
| demag_cnt | input | 16 | Measured demagnetization time of the last cycle, in ticks |
| period_meas | input | 16 | Measured switching period of the last cycle, in ticks |
| period_cmd | output | 16 | Commanded minimum switching period, in ticks |
| ipk_code | output | 8 | Commanded peak-current threshold code |

## Verification
The control law is driven with control words at both edges of every region and at interior points. Edge values show whether each breakpoint falls in the intended region. Interior values show whether the interpolation slopes and their truncation are correct. The current-limit path is tried in four cases:

- duty above the limit, so the period is stretched;
- duty below the limit, so the profile period is kept;
- a stretch that would exceed the slowest period, so it is saturated;
- a stretch shorter than the profile period, so the profile period wins.

The same high duty is then applied below the upper region to show it is ignored there. Strobe-free input changes and a mid-pipeline sample separate the hold behaviour from the two-stage latency.

// File: rtl/clw_pkg.sv
package clw_pkg;

  typedef enum logic [1:0] {
    RGN_SLOW = 2'd0,
    RGN_KNEE = 2'd1,
    RGN_AMPL = 2'd2,
    RGN_FAST = 2'd3
  } clw_region_e;

  // Linear interpolation between (xa,ya) and (xb,yb), truncated toward zero
  function automatic int clw_lerp(input int ya, input int yb,
                                  input int xa, input int xb, input int x);
    return ya + ((yb - ya) * (x - xa)) / (xb - xa);
  endfunction

endpackage

// File: rtl/clw_profile.sv
module clw_profile
  import clw_pkg::*;
#(
  parameter int CW       = 8,
  parameter int PW       = 16,
  parameter int TW       = 8,
  parameter int BP_KNEE  = 38,
  parameter int BP_AMLO  = 112,
  parameter int BP_AMHI  = 181,
  parameter int PER_MIN  = 125,
  parameter int PER_AM   = 357,
  parameter int PER_KNEE = 3030,
  parameter int PER_MAX  = 15385,
  parameter int THR_MAX  = 240,
  parameter int THR_MIN  = 60
) (
  input  logic [CW-1:0] ctrl,
  output clw_region_e   region,
  output logic [PW-1:0] per,
  output logic [TW-1:0] thr
);
  localparam int CTRL_FULL = (1 << CW) - 1;

  int cv;
  int pv;
  int tv;

  always_comb begin
    cv = int'(ctrl);
    if (cv >= BP_AMHI) begin
      region = RGN_FAST;
      pv     = clw_lerp(PER_AM, PER_MIN, BP_AMHI, CTRL_FULL, cv);
      tv     = THR_MAX;
    end else if (cv >= BP_AMLO) begin
      region = RGN_AMPL;
      pv     = PER_AM;
      tv     = clw_lerp(THR_MIN, THR_MAX, BP_AMLO, BP_AMHI, cv);
    end else if (cv >= BP_KNEE) begin
      region = RGN_KNEE;
      pv     = clw_lerp(PER_KNEE, PER_AM, BP_KNEE, BP_AMLO, cv);
      tv     = THR_MIN;
    end else begin
      region = RGN_SLOW;
      pv     = clw_lerp(PER_MAX, PER_KNEE, 0, BP_KNEE, cv);
      tv     = THR_MIN;
    end
    per = PW'(pv);
    thr = TW'(tv);
  end

endmodule

// File: rtl/clw_cc_limit.sv
module clw_cc_limit #(
  parameter int PW       = 16,
  parameter int PER_MAX  = 15385,
  parameter int DUTY_NUM = 17,
  parameter int DUTY_DEN = 40
) (
  input  logic [PW-1:0] demag,
  input  logic [PW-1:0] per_meas,
  output logic          over,
  output logic [PW-1:0] need
);
  localparam int XW = 2 * PW + 8;

  logic [XW-1:0] lhs;
  logic [XW-1:0] rhs;
  logic [XW-1:0] need_full;

  always_comb begin
    lhs       = XW'(demag) * XW'(DUTY_DEN);
    rhs       = XW'(per_meas) * XW'(DUTY_NUM);
    over      = lhs > rhs;
    // smallest period that restores the duty limit (ceiling division)
    need_full = (lhs + XW'(DUTY_NUM - 1)) / XW'(DUTY_NUM);
    need      = (need_full > XW'(PER_MAX)) ? PW'(PER_MAX) : need_full[PW-1:0];
  end

endmodule

// File: rtl/clw_apply.sv
module clw_apply #(
  parameter int PW      = 16,
  parameter int TW      = 8,
  parameter int PER_MAX = 15385,
  parameter int THR_MIN = 60
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic          cc_arm,
  input  logic [PW-1:0] per,
  input  logic [TW-1:0] thr,
  input  logic [PW-1:0] need,
  output logic [PW-1:0] period_cmd,
  output logic [TW-1:0] ipk_code
);
  logic [PW-1:0] per_sel;

  always_comb begin
    per_sel = (cc_arm && (need > per)) ? need : per;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_cmd <= PW'(PER_MAX);
      ipk_code   <= TW'(THR_MIN);
    end else if (vld) begin
      period_cmd <= per_sel;
      ipk_code   <= thr;
    end
  end

endmodule

// File: rtl/fm_am_law.sv
module fm_am_law
  import clw_pkg::*;
#(
  parameter int CW       = 8,
  parameter int PW       = 16,
  parameter int TW       = 8,
  parameter int BP_KNEE  = 38,
  parameter int BP_AMLO  = 112,
  parameter int BP_AMHI  = 181,
  parameter int PER_MIN  = 125,
  parameter int PER_AM   = 357,
  parameter int PER_KNEE = 3030,
  parameter int PER_MAX  = 15385,
  parameter int THR_MAX  = 240,
  parameter int THR_MIN  = 60,
  parameter int DUTY_NUM = 17,
  parameter int DUTY_DEN = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cycle_end,
  input  logic [CW-1:0] ctrl_word,
  input  logic [PW-1:0] demag_cnt,
  input  logic [PW-1:0] period_meas,
  output logic [PW-1:0] period_cmd,
  output logic [TW-1:0] ipk_code
);
  clw_region_e   p_region;
  logic [PW-1:0] p_per;
  logic [TW-1:0] p_thr;
  logic          c_over;
  logic [PW-1:0] c_need;

  clw_profile #(
    .CW(CW), .PW(PW), .TW(TW),
    .BP_KNEE(BP_KNEE), .BP_AMLO(BP_AMLO), .BP_AMHI(BP_AMHI),
    .PER_MIN(PER_MIN), .PER_AM(PER_AM), .PER_KNEE(PER_KNEE), .PER_MAX(PER_MAX),
    .THR_MAX(THR_MAX), .THR_MIN(THR_MIN)
  ) u_profile (
    .ctrl   (ctrl_word),
    .region (p_region),
    .per    (p_per),
    .thr    (p_thr)
  );

  clw_cc_limit #(
    .PW(PW), .PER_MAX(PER_MAX), .DUTY_NUM(DUTY_NUM), .DUTY_DEN(DUTY_DEN)
  ) u_cc (
    .demag    (demag_cnt),
    .per_meas (period_meas),
    .over     (c_over),
    .need     (c_need)
  );

  // stage 1: capture profile and current-limit results at the strobe
  logic          s1_vld;
  logic          s1_arm;
  logic [PW-1:0] s1_per;
  logic [TW-1:0] s1_thr;
  logic [PW-1:0] s1_need;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_arm  <= 1'b0;
      s1_per  <= PW'(PER_MAX);
      s1_thr  <= TW'(THR_MIN);
      s1_need <= '0;
    end else begin
      s1_vld <= cycle_end;
      if (cycle_end) begin
        s1_arm  <= (p_region == RGN_FAST) && c_over;
        s1_per  <= p_per;
        s1_thr  <= p_thr;
        s1_need <= c_need;
      end
    end
  end

  // stage 2: merge and register the outputs
  clw_apply #(
    .PW(PW), .TW(TW), .PER_MAX(PER_MAX), .THR_MIN(THR_MIN)
  ) u_apply (
    .clk        (clk),
    .rst        (rst),
    .vld        (s1_vld),
    .cc_arm     (s1_arm),
    .per        (s1_per),
    .thr        (s1_thr),
    .need       (s1_need),
    .period_cmd (period_cmd),
    .ipk_code   (ipk_code)
  );

endmodule

// File: rtl/fm_am_law_chk.sv
module fm_am_law_chk #(
  parameter int PW      = 16,
  parameter int TW      = 8,
  parameter int PER_MIN = 125,
  parameter int PER_AM  = 357,
  parameter int PER_MAX = 15385,
  parameter int THR_MAX = 240,
  parameter int THR_MIN = 60
) (
  input logic          clk,
  input logic          rst,
  input logic          s1_vld,
  input logic [PW-1:0] period_cmd,
  input logic [TW-1:0] ipk_code
);
  // R8
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(s1_vld) |-> ($stable(period_cmd) && $stable(ipk_code)));

  // R9
  period_range_chk: assert property (@(posedge clk) disable iff (rst)
    (period_cmd >= PW'(PER_MIN)) && (period_cmd <= PW'(PER_MAX)));

  // R9
  thr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ipk_code >= TW'(THR_MIN)) && (ipk_code <= TW'(THR_MAX)));

  // R2
  fast_needs_max_chk: assert property (@(posedge clk) disable iff (rst)
    (period_cmd < PW'(PER_AM)) |-> (ipk_code == TW'(THR_MAX)));

  // R3
  ampl_band_period_chk: assert property (@(posedge clk) disable iff (rst)
    ((ipk_code > TW'(THR_MIN)) && (ipk_code < TW'(THR_MAX))) |-> (period_cmd == PW'(PER_AM)));

  // R4
  slow_needs_min_chk: assert property (@(posedge clk) disable iff (rst)
    ((period_cmd > PW'(PER_AM)) && (ipk_code != TW'(THR_MAX))) |-> (ipk_code == TW'(THR_MIN)));
endmodule

bind fm_am_law fm_am_law_chk #(
  .PW(PW), .TW(TW), .PER_MIN(PER_MIN), .PER_AM(PER_AM), .PER_MAX(PER_MAX),
  .THR_MAX(THR_MAX), .THR_MIN(THR_MIN)
) u_law_chk (
  .clk        (clk),
  .rst        (rst),
  .s1_vld     (s1_vld),
  .period_cmd (period_cmd),
  .ipk_code   (ipk_code)
);

// File: tb/fm_am_law_test.sv
module fm_am_law_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cycle_end = 1'b0;
  logic [7:0]  ctrl_word = '0;
  logic [15:0] demag_cnt = '0;
  logic [15:0] period_meas = '0;
  logic [15:0] period_cmd;
  logic [7:0]  ipk_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fm_am_law uut (
    .clk(clk), .rst(rst), .cycle_end(cycle_end), .ctrl_word(ctrl_word),
    .demag_cnt(demag_cnt), .period_meas(period_meas),
    .period_cmd(period_cmd), .ipk_code(ipk_code)
  );

  function automatic int exp_thr(input int c);
    if (c >= 181) return 240;
    if (c >= 112) return 60 + (180 * (c - 112)) / 69;
    return 60;
  endfunction

  function automatic int exp_per(input int c, input int d, input int m);
    int p;
    int need;
    if (c >= 181)      p = 357 - (232 * (c - 181)) / 74;
    else if (c >= 112) p = 357;
    else if (c >= 38)  p = 3030 - (2673 * (c - 38)) / 74;
    else               p = 15385 - (12355 * c) / 38;
    if (c >= 181 && d * 40 > m * 17) begin
      need = (d * 40 + 16) / 17;
      if (need > 15385) need = 15385;
      if (need > p) p = need;
    end
    return p;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int c, input int d, input int m);
    @(negedge clk);
    ctrl_word = 8'(c); demag_cnt = 16'(d); period_meas = 16'(m);
    cycle_end = 1'b1;
    @(negedge clk);
    cycle_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_point(input string req, input int c, input int d, input int m);
    apply(c, d, m);
    check(req, int'(period_cmd), exp_per(c, d, m));
    check(req, int'(ipk_code), exp_thr(c));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 period", int'(period_cmd), 15385);
    check("R1 thr", int'(ipk_code), 60);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 period after release", int'(period_cmd), 15385);
    check("R1 thr after release", int'(ipk_code), 60);
  endtask

  task automatic t_fast;
    run_point("R2 c=181", 181, 0, 100);
    run_point("R2 c=218", 218, 0, 100);
    run_point("R2 c=255", 255, 0, 100);
    check("R2 top period", int'(period_cmd), 125);
  endtask

  task automatic t_ampl;
    run_point("R3 c=180", 180, 0, 100);
    run_point("R3 c=146", 146, 0, 100);
    run_point("R3 c=112", 112, 0, 100);
  endtask

  task automatic t_knee;
    run_point("R4 c=111", 111, 0, 100);
    run_point("R4 c=75", 75, 0, 100);
    run_point("R4 c=38", 38, 0, 100);
  endtask

  task automatic t_slow;
    run_point("R5 c=37", 37, 0, 100);
    run_point("R5 c=19", 19, 0, 100);
    run_point("R5 c=0", 0, 0, 100);
    check("R9 slowest", int'(period_cmd), 15385);
  endtask

  task automatic t_cc;
    run_point("R6 stretch", 255, 100, 200);
    check("R6 stretch value", int'(period_cmd), 236);
    run_point("R6 under limit", 255, 80, 200);
    run_point("R6 saturate", 255, 8000, 10000);
    check("R6 saturate value", int'(period_cmd), 15385);
    run_point("R6 profile wins", 200, 100, 200);
    check("R6 profile wins value", int'(period_cmd), 298);
  endtask

  task automatic t_ignored;
    run_point("R7 ampl high duty", 150, 100, 200);
    check("R7 ampl period", int'(period_cmd), 357);
    run_point("R7 slow high duty", 20, 8000, 10000);
    check("R7 slow period", int'(period_cmd), exp_per(20, 0, 1));
  endtask

  task automatic t_timing;
    int p0;
    int t0;
    run_point("R8 base", 100, 0, 100);
    p0 = int'(period_cmd);
    t0 = int'(ipk_code);
    @(negedge clk);
    ctrl_word = 8'd255; demag_cnt = 16'd500; period_meas = 16'd600;
    repeat (5) @(negedge clk);
    check("R8 hold period", int'(period_cmd), p0);
    check("R8 hold thr", int'(ipk_code), t0);
    cycle_end = 1'b1;
    @(negedge clk);
    cycle_end = 1'b0;
    check("R8 one edge period", int'(period_cmd), p0);
    check("R8 one edge thr", int'(ipk_code), t0);
    @(negedge clk);
    check("R8 two edges period", int'(period_cmd), exp_per(255, 500, 600));
    check("R8 two edges thr", int'(ipk_code), 240);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_fast();
    t_ampl();
    t_knee();
    t_slow();
    t_cc();
    t_ignored();
    t_timing();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule